// File: doc/BRIEF.md
# Latched Page Select Decoder

The block turns a page field of a 13-bit address bus into thirty-two active-high page selects. Each select covers 256 bytes, so together they span 0x0000 to 0x1FFF. Inside, two identical decode units each hold a 4-bit page field in their own storage element. Each unit turns its stored value into sixteen one-hot lines. A per-unit blank input forces all sixteen lines low. Bus bit 12 is not stored. It blanks the unit it does not select: unit 0 is blanked when bit 12 is 1, and unit 1 is blanked when bit 12 is 0. A shared `blank` input blanks both units at once.

Three uses follow from this. The first is plain address decoding. The second is one-bit demultiplexing: the address picks the line, and `blank` carries the inverted data bit. The third is cascading units into a wider page decoder. By default the storage is a level-sensitive latch: it is transparent while `track` is high and it holds while `track` is low. A parameter swaps in an edge-triggered register for flows that do not allow latches. There is no register stage between the stored field and the outputs.

Top module: `page_select_decoder`

## Requirements
- R1: With `blank` low, exactly the line `page_sel[{bus_addr[12], F}]` is high, where F is the stored copy of `bus_addr[11:8]` (bit 11 most significant). Line i covers bytes 256*i to 256*i+255.
- R2: In the latch variant, while `track` is high the stored field equals `bus_addr[11:8]`. The outputs follow that field with no clock edge in between.
- R3: While `track` is low, the stored field keeps its last value. Changes on `bus_addr[11:0]` then leave `page_sel` unchanged.
- R4: `bus_addr[12]` is never stored. While `track` is low, changing bit 12 moves the active line to the other unit at the same held field. A blanked unit drives all of its sixteen lines low.
- R5: With `blank` high, all thirty-two lines are low, whatever the values of `track` and `bus_addr`.
- R6: The storage keeps loading while `blank` is high. A field taken in while blanked appears on its line once `blank` falls.
- R7: With `blank` low, exactly one of the thirty-two lines is high.
- R8: For demultiplexing with the field held, the selected line equals the inverse of `blank`, and every other line stays low.
- R9: A change on `blank` or on `bus_addr[12]` reaches `page_sel` without waiting for a clock edge.
- R10: With `CLOCKED` set, the field is taken only at a rising `clk` edge while `track` is high, and `rst_n` low clears it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. It is used only by the edge-triggered storage variant. |
| rst_n | input | 1 | Active-low asynchronous clear. It affects only the edge-triggered storage variant. |
| track | input | 1 | 1: the storage takes in the page field; 0: the storage holds its value. |
| blank | input | 1 | Active high. Forces every page select low. |
| bus_addr | input | ADDR_W (13) | Address bus. Bits 11:8 are the stored page field; bit 12 chooses the unit; bits 7:0 are unused. |
| page_sel | output | 2^(ADDR_W-PAGE_LSB) (32) | One-hot page selects, active high. |

## Verification
The properties are sampled at rising clock edges, while the latch reacts to levels. They therefore assume that `track`, `blank` and `bus_addr` stay constant through each clock period. They also assume that `track` never falls in the same instant that the page field moves, since that would be a setup race on the latch. The stimulus changes inputs only at falling edges. When it enters hold, it first lowers `track` with the address unchanged, and only moves the address in a later step. Every output is sampled one time unit after the inputs change, so the combinational path is checked without any edge in between.

// File: rtl/pgdec_pkg.sv
package pgdec_pkg;

  localparam int PG_ADDR_W   = 13;
  localparam int PG_PAGE_LSB = 8;
  localparam int PG_SEL_W    = 4;

  // A unit is blanked by the shared blank or when the upper bits name another unit.
  function automatic logic unit_cs(input logic blank, input logic hit);
    return blank | ~hit;
  endfunction

  // Flat page number built from unit number and stored field.
  function automatic int unsigned page_index(input int unsigned unit,
                                             input int unsigned field,
                                             input int unsigned sel_w);
    return (unit << sel_w) | field;
  endfunction

endpackage

// File: rtl/pgdec_addr_store.sv
module pgdec_addr_store #(
  parameter int SEL_W   = 4,
  parameter bit CLOCKED = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             track,
  input  logic [SEL_W-1:0] d,
  output logic [SEL_W-1:0] q
);

  if (CLOCKED) begin : g_flop
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (track) q <= d;
    end
  end else begin : g_latch
    // Transparent while track is high; no reset on the level-sensitive store.
    always_latch begin
      if (track) q <= d;
    end
    logic unused_ctrl;
    assign unused_ctrl = clk ^ rst_n;
  end

endmodule

// File: rtl/pgdec_onehot.sv
module pgdec_onehot #(
  parameter int SEL_W = 4,
  localparam int OUT_W = 1 << SEL_W
) (
  input  logic             cs,
  input  logic [SEL_W-1:0] idx,
  output logic [OUT_W-1:0] y
);

  for (genvar i = 0; i < OUT_W; i++) begin : g_line
    assign y[i] = ~cs & (idx == SEL_W'(i));
  end

endmodule

// File: rtl/pgdec_unit.sv
module pgdec_unit #(
  parameter int SEL_W   = 4,
  parameter bit CLOCKED = 1'b0,
  localparam int OUT_W  = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             track,
  input  logic             cs,
  input  logic [SEL_W-1:0] sel,
  output logic [SEL_W-1:0] held,
  output logic [OUT_W-1:0] y
);

  pgdec_addr_store #(.SEL_W(SEL_W), .CLOCKED(CLOCKED)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .track (track),
    .d     (sel),
    .q     (held)
  );

  pgdec_onehot #(.SEL_W(SEL_W)) u_dec (
    .cs  (cs),
    .idx (held),
    .y   (y)
  );

endmodule

// File: rtl/page_select_decoder.sv
module page_select_decoder
  import pgdec_pkg::*;
#(
  parameter int ADDR_W   = PG_ADDR_W,
  parameter int PAGE_LSB = PG_PAGE_LSB,
  parameter int SEL_W    = PG_SEL_W,
  parameter bit CLOCKED  = 1'b0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              track,
  input  logic                              blank,
  input  logic [ADDR_W-1:0]                 bus_addr,
  output logic [(1<<(ADDR_W-PAGE_LSB))-1:0] page_sel
);

  localparam int UNIT_W  = ADDR_W - PAGE_LSB - SEL_W;
  localparam int N_UNITS = 1 << UNIT_W;
  localparam int OUT_W   = 1 << SEL_W;

  logic [UNIT_W-1:0]        upper;
  logic [SEL_W-1:0]         field;
  logic [N_UNITS-1:0]       unit_blank;
  logic [N_UNITS*SEL_W-1:0] held_flat;
  logic                     unused_low;

  assign upper      = bus_addr[ADDR_W-1 -: UNIT_W];
  assign field      = bus_addr[PAGE_LSB +: SEL_W];
  assign unused_low = ^bus_addr[PAGE_LSB-1:0];

  for (genvar k = 0; k < N_UNITS; k++) begin : g_unit
    assign unit_blank[k] = unit_cs(blank, upper == UNIT_W'(k));

    pgdec_unit #(.SEL_W(SEL_W), .CLOCKED(CLOCKED)) u_unit (
      .clk   (clk),
      .rst_n (rst_n),
      .track (track),
      .cs    (unit_blank[k]),
      .sel   (field),
      .held  (held_flat[k*SEL_W +: SEL_W]),
      .y     (page_sel[k*OUT_W +: OUT_W])
    );
  end

endmodule

// File: rtl/page_select_decoder_chk.sv
module page_select_decoder_chk
  import pgdec_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int PAGE_LSB = 8,
  parameter int SEL_W    = 4,
  parameter bit CLOCKED  = 1'b0,
  localparam int UNIT_W  = ADDR_W - PAGE_LSB - SEL_W,
  localparam int N_UNITS = 1 << UNIT_W,
  localparam int OUT_W   = 1 << SEL_W,
  localparam int PAGES   = N_UNITS * OUT_W
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       track,
  input logic                       blank,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [PAGES-1:0]           page_sel,
  input logic [N_UNITS-1:0]         unit_blank,
  input logic [N_UNITS*SEL_W-1:0]   held_flat
);

  logic [UNIT_W-1:0] upper;
  assign upper = bus_addr[ADDR_W-1 -: UNIT_W];

  p_blank_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> page_sel == '0);

  p_one_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !blank |-> $countones(page_sel) == 1);

  p_index_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !blank |-> page_sel[page_index(upper, held_flat[upper*SEL_W +: SEL_W], SEL_W)]);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!track && $past(!track)) |-> $stable(held_flat));

  for (genvar k = 0; k < N_UNITS; k++) begin : g_u
    p_unit_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      unit_blank[k] |-> page_sel[k*OUT_W +: OUT_W] == '0);
    if (!CLOCKED) begin : g_lat
      p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        track |-> held_flat[k*SEL_W +: SEL_W] == bus_addr[PAGE_LSB +: SEL_W]);
    end
  end

endmodule

bind page_select_decoder page_select_decoder_chk #(
  .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .SEL_W(SEL_W), .CLOCKED(CLOCKED)
) u_chk (
  .clk(clk), .rst_n(rst_n), .track(track), .blank(blank), .bus_addr(bus_addr),
  .page_sel(page_sel), .unit_blank(unit_blank), .held_flat(held_flat)
);

// File: tb/page_select_decoder_test.sv
module page_select_decoder_test;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        track = 1'b1;
  logic        blank = 1'b1;
  logic [12:0] bus_addr = '0;
  logic [31:0] page_sel;
  logic [31:0] page_sel_clk;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  page_select_decoder uut (
    .clk(clk), .rst_n(rst_n), .track(track), .blank(blank),
    .bus_addr(bus_addr), .page_sel(page_sel)
  );

  page_select_decoder #(.CLOCKED(1'b1)) uut_clk (
    .clk(clk), .rst_n(rst_n), .track(track), .blank(blank),
    .bus_addr(bus_addr), .page_sel(page_sel_clk)
  );

  function automatic logic [31:0] line(input int unit, input int fld);
    return 32'(1) << (unit * 16 + fld);
  endfunction

  function automatic logic [12:0] mk(input int unit, input int fld, input int low);
    return 13'(unit * 4096 + fld * 256 + (low & 255));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [12:0] a, input logic tr, input logic bl);
    @(negedge clk);
    bus_addr = a; track = tr; blank = bl;
    #1;
  endtask

  task automatic t_reset;
    chk("R5 reset blank", page_sel, '0);
    bus_addr = mk(0, 5, 0); blank = 1'b0; #1;
    chk("R10 clocked cleared", page_sel_clk, line(0, 0));
    chk("R2 reset transparent", page_sel, line(0, 5));
  endtask

  task automatic t_transparent;
    for (int p = 0; p < 32; p++) begin
      drive(mk(p / 16, p % 16, p * 37), 1'b1, 1'b0);
      chk("R1 R2 page", page_sel, line(p / 16, p % 16));
      if (p % 8 == 3) chk("R7 one line", 32'($countones(page_sel)), 32'd1);
    end
  endtask

  task automatic t_hold;
    drive(mk(0, 5, 0), 1'b1, 1'b0);
    drive(mk(0, 5, 0), 1'b0, 1'b0);
    for (int f = 0; f < 16; f++) begin
      drive(mk(0, f, f * 19), 1'b0, 1'b0);
      chk("R3 held", page_sel, line(0, 5));
    end
    drive(mk(1, 12, 0), 1'b0, 1'b0);
    chk("R4 top bit live", page_sel, line(1, 5));
    drive(mk(0, 9, 0), 1'b0, 1'b0);
    chk("R4 back to unit 0", page_sel, line(0, 5));
  endtask

  task automatic t_blank;
    for (int i = 0; i < 8; i++) begin
      drive(mk(i % 2, i * 3, i), 1'(i / 4), 1'b1);
      chk("R5 blank overrides", page_sel, '0);
    end
    drive(mk(0, 9, 0), 1'b1, 1'b1);
    drive(mk(0, 9, 0), 1'b0, 1'b1);
    chk("R5 blank while held", page_sel, '0);
    drive(mk(0, 9, 0), 1'b0, 1'b0);
    chk("R6 loaded under blank", page_sel, line(0, 9));
  endtask

  task automatic t_demux;
    logic [7:0] data = 8'b1011_0010;
    drive(mk(1, 3, 0), 1'b1, 1'b0);
    drive(mk(1, 3, 0), 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      drive(mk(1, 3, 0), 1'b0, ~data[i]);
      chk("R8 R9 demux line", page_sel, data[i] ? line(1, 3) : 32'd0);
    end
  endtask

  task automatic t_clocked;
    drive(mk(0, 7, 0), 1'b1, 1'b0);
    @(posedge clk); #1;
    chk("R10 captured", page_sel_clk, line(0, 7));
    drive(mk(0, 11, 0), 1'b1, 1'b0);
    chk("R10 waits for edge", page_sel_clk, line(0, 7));
    @(posedge clk); #1;
    chk("R10 after edge", page_sel_clk, line(0, 11));
    drive(mk(0, 11, 0), 1'b0, 1'b0);
    drive(mk(0, 2, 0), 1'b0, 1'b0);
    @(posedge clk); #1;
    chk("R10 hold on edge", page_sel_clk, line(0, 11));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    t_transparent;
    t_hold;
    t_blank;
    t_demux;
    t_clocked;
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule